// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block walks a ring of transmit descriptors held in system memory and turns the buffers they point to into outgoing frames. Software loads the ring base address, fills descriptors and hands them to the engine by setting their ownership bit, then pulses a poll-demand input. The engine reads one 32-byte descriptor at a time through a word-wide memory port. It fetches the descriptor's buffer into an internal frame store. When the descriptor closes a frame, the engine plays the whole frame out as a byte stream. It then writes the control word back with ownership cleared and moves on to the next descriptor.

A scan ends at the first descriptor the engine does not own, at a descriptor with an illegal buffer size, or at one that would push the frame past the store's capacity. The current pointer stays on that descriptor, and any partly gathered frame is dropped when the next scan begins. Each finished frame raises a one-cycle transmit-complete strobe, which feeds the interrupt and summary bits of a status register elsewhere. A poll that arrives while a scan is running is held and starts a fresh scan once the current one stops.

Memory protocol: `mem_req_o` with `mem_we_o` low is a read of `mem_addr_o`, and its data is presented on `mem_rdata_i` in the following cycle. With `mem_we_o` high it is a write of `mem_wdata_o`. The memory never stalls.

Top module: `txr_desc_engine`

## Requirements
- R1: After reset the engine is idle: `busy_o`, `mem_req_o`, `tx_valid_o` and `tx_done_o` are low.
- R2: A `base_we_i` pulse loads both the ring base and the current pointer from `base_addr_i`, which must be 32-byte aligned. A `poll_i` pulse while idle starts a scan whose first access is a read of the control word at the current pointer.
- R3: If bit 31 (ownership) of the control word read is 0, the scan stops after that single read. There is no further access, no write and no pointer movement, and the engine returns to idle.
- R4: The size word is descriptor word 1. Buffer-1 length is its bits 11:0 and buffer-2 length its bits 27:16. The buffer-1 address is word 2. The engine reads words 0, 1 and 2 in that order. If buffer-1 length exceeds 2048 or buffer-2 length is nonzero, it stops with no buffer read and no write-back. A length of exactly 2048 is accepted.
- R5: If the bytes already gathered in this scan plus the buffer-1 length would reach 8192, the scan stops with no buffer read and no write-back.
- R6: The buffer is read as ceil(len/4) consecutive words starting at the buffer-1 address with its low two bits ignored. Byte j of each word (bits 8j+7:8j) comes before byte j+1, and bytes of the final word beyond the length are discarded.
- R7: When control bit 29 (last segment) is set, the gathered frame is played out one byte per cycle with `tx_last_o` on its final byte. `tx_done_o` pulses for one cycle in the following cycle. A zero-length frame plays no bytes but still pulses `tx_done_o`.
- R8: After its buffer is taken, and after the frame has played out if the descriptor was the last segment, the descriptor's control word is written back once to its own address with bit 31 cleared and all other bits unchanged. No other descriptor word is written.
- R9: After the write-back, the current pointer returns to the ring base if control bit 21 (ring end) is set, and otherwise advances by 32 bytes. The next descriptor is then read.
- R10: Poll pulses arriving while a scan runs, including one in the very cycle the scan stops, cause exactly one further scan. Every scan starts with an empty frame, so bytes gathered before a stop are never played out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| poll_i | input | 1 | Poll-demand strobe |
| base_we_i | input | 1 | Load ring base and current pointer |
| base_addr_i | input | 32 | Ring base address, 32-byte aligned |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 32 | Byte address of the word accessed |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, one cycle after the request |
| tx_valid_o | output | 1 | Frame byte valid |
| tx_data_o | output | 8 | Frame byte |
| tx_last_o | output | 1 | Final byte of the frame |
| tx_done_o | output | 1 | Transmit-complete strobe |
| busy_o | output | 1 | A scan is in progress |

## Verification
Two functions can meet in a single cycle: the stop decision, taken in the cycle the unowned or bad descriptor word returns, and a new poll demand. The bench provokes this in two ways. In the first, it watches for the control-word read of an unowned descriptor and raises `poll_i` for exactly the following cycle, which is the stop cycle. In the second, it pulses `poll_i` three times while a frame is playing out, so the held poll must survive until the stop. In both cases the outcome is judged against the reference model's event list: exactly one more scan, a repeat control-word read at the same pointer, and then idle with no further memory traffic.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int unsigned DESC_BYTES   = 32;
  localparam int unsigned OWN_BIT      = 31;
  localparam int unsigned LAST_BIT     = 29;
  localparam int unsigned RING_END_BIT = 21;
  localparam int unsigned SIZE_W       = 12;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_CTL, S_RD_SIZE, S_RD_ADDR, S_CHECK,
    S_FETCH, S_DRAIN, S_POST, S_EMIT, S_WB
  } walk_state_e;
endpackage

// File: rtl/txr_frame_buf.sv
module txr_frame_buf #(
  parameter int unsigned MAX_BYTES = 8192,
  localparam int unsigned PW       = $clog2(MAX_BYTES),
  localparam int unsigned DEPTH    = MAX_BYTES / 4
) (
  input  logic          clk_i,
  input  logic          wr_en_i,
  input  logic [PW-1:0] wr_pos_i,
  input  logic [31:0]   wr_word_i,
  input  logic [2:0]    wr_cnt_i,
  input  logic [PW-1:0] rd_pos_i,
  output logic [7:0]    rd_byte_o
);
  logic [31:0]   mem [DEPTH];
  logic [PW-1:0] lane_pos [4];
  logic [3:0]    lane_en;

  for (genvar k = 0; k < 4; k++) begin : g_lane
    assign lane_pos[k] = wr_pos_i + PW'(k);
    assign lane_en[k]  = wr_en_i && (3'(k) < wr_cnt_i);
  end

  always_ff @(posedge clk_i) begin
    for (int k = 0; k < 4; k++) begin
      if (lane_en[k])
        mem[lane_pos[k][PW-1:2]][{lane_pos[k][1:0], 3'b000} +: 8] <= wr_word_i[8*k +: 8];
    end
  end

  logic [31:0] rd_word;
  assign rd_word   = mem[rd_pos_i[PW-1:2]];
  assign rd_byte_o = rd_word[{rd_pos_i[1:0], 3'b000} +: 8];
endmodule

// File: rtl/txr_emitter.sv
module txr_emitter #(
  parameter int unsigned MAX_BYTES = 8192,
  localparam int unsigned PW       = $clog2(MAX_BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [PW-1:0] len_i,
  output logic [PW-1:0] rd_pos_o,
  input  logic [7:0]    rd_byte_i,
  output logic          valid_o,
  output logic [7:0]    data_o,
  output logic          last_o,
  output logic          done_o
);
  logic          active_q, done_q;
  logic [PW-1:0] idx_q, len_q;

  assign valid_o  = active_q;
  assign rd_pos_o = idx_q;
  assign data_o   = rd_byte_i;
  assign last_o   = active_q && (idx_q == len_q - PW'(1));
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      idx_q    <= '0;
      len_q    <= '0;
    end else begin
      done_q <= last_o || (start_i && len_i == '0);
      if (start_i) begin
        len_q    <= len_i;
        idx_q    <= '0;
        active_q <= (len_i != '0);
      end else if (active_q) begin
        idx_q <= idx_q + PW'(1);
        if (last_o) active_q <= 1'b0;
      end
    end
  end

  AST_LAST_THEN_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> (done_o && !valid_o));                          // R7
  AST_BYTES_BACK_TO_BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !last_o) |=> valid_o);                         // R7
endmodule

// File: rtl/txr_walker.sv
module txr_walker
  import txr_pkg::*;
#(
  parameter int unsigned MAX_BYTES = 8192,
  parameter int unsigned B1_LIMIT  = 2048,
  localparam int unsigned PW       = $clog2(MAX_BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          poll_i,
  input  logic          base_we_i,
  input  logic [31:0]   base_addr_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [31:0]   mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic [31:0]   mem_rdata_i,
  output logic          buf_we_o,
  output logic [PW-1:0] buf_pos_o,
  output logic [2:0]    buf_cnt_o,
  output logic          emit_start_o,
  output logic [PW-1:0] emit_len_o,
  input  logic          emit_done_i,
  output logic          busy_o
);
  walk_state_e       state_q;
  logic [31:0]       cur_q, base_q, ctl_q, fetch_addr_q;
  logic [SIZE_W-1:0] b1_q, rem_q;
  logic              b2_nz_q, pend_q, pend_rd_q;
  logic [2:0]        pend_cnt_q, issue_cnt;
  logic [PW-1:0]     frame_q;
  logic [PW:0]       frame_sum;
  logic              own_miss, bad_desc, stop, go_again, start_scan;

  assign issue_cnt  = (rem_q >= SIZE_W'(4)) ? 3'd4 : rem_q[2:0];
  assign frame_sum  = {1'b0, frame_q} + (PW+1)'(b1_q);
  assign own_miss   = (state_q == S_RD_SIZE) && !mem_rdata_i[OWN_BIT];
  assign bad_desc   = (state_q == S_CHECK) &&
                      ((b1_q > SIZE_W'(B1_LIMIT)) || b2_nz_q ||
                       (frame_sum >= (PW+1)'(MAX_BYTES)));
  assign stop       = own_miss || bad_desc;
  assign go_again   = stop && (pend_q || poll_i);
  assign start_scan = ((state_q == S_IDLE) && poll_i) || go_again;

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    unique case (state_q)
      S_RD_CTL:  begin mem_req_o = 1'b1; mem_addr_o = cur_q; end
      S_RD_SIZE: begin mem_req_o = mem_rdata_i[OWN_BIT]; mem_addr_o = cur_q + 32'd4; end
      S_RD_ADDR: begin mem_req_o = 1'b1; mem_addr_o = cur_q + 32'd8; end
      S_FETCH:   begin mem_req_o = 1'b1; mem_addr_o = fetch_addr_q; end
      S_WB: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = cur_q;
        mem_wdata_o = ctl_q & ~(32'd1 << OWN_BIT);
      end
      default: ;
    endcase
  end

  assign buf_we_o     = pend_rd_q;
  assign buf_pos_o    = frame_q;
  assign buf_cnt_o    = pend_cnt_q;
  assign emit_start_o = (state_q == S_POST) && ctl_q[LAST_BIT];
  assign emit_len_o   = frame_q;
  assign busy_o       = (state_q != S_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= S_IDLE;
      cur_q        <= '0;
      base_q       <= '0;
      ctl_q        <= '0;
      fetch_addr_q <= '0;
      b1_q         <= '0;
      rem_q        <= '0;
      b2_nz_q      <= 1'b0;
      pend_q       <= 1'b0;
      pend_rd_q    <= 1'b0;
      pend_cnt_q   <= '0;
      frame_q      <= '0;
    end else begin
      pend_q     <= go_again ? 1'b0 : (pend_q || (poll_i && state_q != S_IDLE));
      pend_rd_q  <= (state_q == S_FETCH);
      pend_cnt_q <= issue_cnt;

      if (start_scan || (state_q == S_EMIT && emit_done_i)) frame_q <= '0;
      else if (pend_rd_q) frame_q <= frame_q + PW'(pend_cnt_q);

      if (base_we_i) base_q <= base_addr_i;
      if (base_we_i) cur_q <= base_addr_i;
      else if (state_q == S_WB)
        cur_q <= ctl_q[RING_END_BIT] ? base_q : cur_q + 32'(DESC_BYTES);

      unique case (state_q)
        S_IDLE:   if (poll_i) state_q <= S_RD_CTL;
        S_RD_CTL: state_q <= S_RD_SIZE;
        S_RD_SIZE: begin
          ctl_q <= mem_rdata_i;
          if (own_miss) state_q <= go_again ? S_RD_CTL : S_IDLE;
          else          state_q <= S_RD_ADDR;
        end
        S_RD_ADDR: begin
          b1_q    <= mem_rdata_i[SIZE_W-1:0];
          b2_nz_q <= |mem_rdata_i[16 +: SIZE_W];
          state_q <= S_CHECK;
        end
        S_CHECK: begin
          fetch_addr_q <= {mem_rdata_i[31:2], 2'b00};
          rem_q        <= b1_q;
          if (bad_desc)          state_q <= go_again ? S_RD_CTL : S_IDLE;
          else if (b1_q == '0)   state_q <= S_POST;
          else                   state_q <= S_FETCH;
        end
        S_FETCH: begin
          fetch_addr_q <= fetch_addr_q + 32'd4;
          rem_q        <= rem_q - SIZE_W'(issue_cnt);
          if (rem_q <= SIZE_W'(4)) state_q <= S_DRAIN;
        end
        S_DRAIN: state_q <= S_POST;
        S_POST:  state_q <= ctl_q[LAST_BIT] ? S_EMIT : S_WB;
        S_EMIT:  if (emit_done_i) state_q <= S_WB;
        S_WB:    state_q <= S_RD_CTL;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  AST_WB_AT_DESC_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_addr_o[4:0] == 5'd0));                   // R8
  AST_WB_ONLY_OWNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> ctl_q[OWN_BIT]);                              // R3
  AST_FETCH_SIZE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_FETCH) |-> ((b1_q <= SIZE_W'(B1_LIMIT)) && !b2_nz_q)); // R4
  AST_FRAME_BELOW_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_POST) |-> ({1'b0, frame_q} < (PW+1)'(MAX_BYTES))); // R5
  AST_POLL_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (poll_i && state_q != S_IDLE) |=> (pend_q || state_q == S_RD_CTL)); // R10
endmodule

// File: rtl/txr_desc_engine.sv
module txr_desc_engine #(
  parameter int unsigned MAX_FRAME_BYTES = 8192,
  parameter int unsigned B1_LIMIT        = 2048,
  localparam int unsigned PW             = $clog2(MAX_FRAME_BYTES)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        poll_i,
  input  logic        base_we_i,
  input  logic [31:0] base_addr_i,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic [31:0] mem_addr_o,
  output logic [31:0] mem_wdata_o,
  input  logic [31:0] mem_rdata_i,
  output logic        tx_valid_o,
  output logic [7:0]  tx_data_o,
  output logic        tx_last_o,
  output logic        tx_done_o,
  output logic        busy_o
);
  logic          buf_we, emit_start, emit_done;
  logic [PW-1:0] buf_pos, emit_len, rd_pos;
  logic [2:0]    buf_cnt;
  logic [7:0]    rd_byte;

  txr_walker #(.MAX_BYTES(MAX_FRAME_BYTES), .B1_LIMIT(B1_LIMIT)) i_walker (
    .clk_i, .rst_ni, .poll_i, .base_we_i, .base_addr_i,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_rdata_i,
    .buf_we_o(buf_we), .buf_pos_o(buf_pos), .buf_cnt_o(buf_cnt),
    .emit_start_o(emit_start), .emit_len_o(emit_len), .emit_done_i(emit_done),
    .busy_o
  );

  txr_frame_buf #(.MAX_BYTES(MAX_FRAME_BYTES)) i_frame_buf (
    .clk_i, .wr_en_i(buf_we), .wr_pos_i(buf_pos), .wr_word_i(mem_rdata_i),
    .wr_cnt_i(buf_cnt), .rd_pos_i(rd_pos), .rd_byte_o(rd_byte)
  );

  txr_emitter #(.MAX_BYTES(MAX_FRAME_BYTES)) i_emitter (
    .clk_i, .rst_ni, .start_i(emit_start), .len_i(emit_len),
    .rd_pos_o(rd_pos), .rd_byte_i(rd_byte),
    .valid_o(tx_valid_o), .data_o(tx_data_o), .last_o(tx_last_o), .done_o(emit_done)
  );

  assign tx_done_o = emit_done;
endmodule

// File: tb/test_txr_desc_engine.sv
module test_txr_desc_engine;
  localparam int EV_RD = 0, EV_WR = 1, EV_BYTE = 2, EV_DONE = 3;
  localparam logic [31:0] OWN = 32'h8000_0000, LST = 32'h2000_0000, RNG = 32'h0020_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic poll = 1'b0, base_we = 1'b0;
  logic [31:0] base_addr = '0, rdata = '0;
  logic mem_req, mem_we, tx_valid, tx_last, tx_done, busy;
  logic [31:0] mem_addr, mem_wdata;
  logic [7:0] tx_data;

  always #2 clk = ~clk;

  txr_desc_engine i_txr_desc_engine (
    .clk_i(clk), .rst_ni(rst_n), .poll_i(poll), .base_we_i(base_we), .base_addr_i(base_addr),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(rdata), .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_last_o(tx_last),
    .tx_done_o(tx_done), .busy_o(busy)
  );

  logic [31:0] bmem [0:2047];
  logic [31:0] mm   [0:2047];

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) bmem[mem_addr[12:2]] <= mem_wdata;
      else        rdata <= bmem[mem_addr[12:2]];
    end
  end

  typedef struct {
    int kind;
    logic [31:0] a;
    logic [31:0] d;
    bit last;
    string tag;
  } ev_t;
  ev_t expq[$];

  int vectors = 0, errors = 0, cyc = 0;
  bit mon_en = 1'b0;
  logic [31:0] m_base = '0, m_cur = '0;

  task automatic push_ev(input int kind, input logic [31:0] a, input logic [31:0] d,
                         input bit last, input string tag);
    ev_t e;
    e.kind = kind; e.a = a; e.d = d; e.last = last; e.tag = tag;
    expq.push_back(e);
  endtask

  task automatic set_w(input logic [31:0] a, input logic [31:0] v);
    bmem[a[12:2]] = v;
    mm[a[12:2]]   = v;
  endtask

  task automatic set_desc(input logic [31:0] a, input logic [31:0] ctl,
                          input logic [31:0] sz, input logic [31:0] ba);
    set_w(a, ctl); set_w(a + 4, sz); set_w(a + 8, ba);
  endtask

  // Behavioural walk over the model memory: builds the expected event list.
  task automatic model_walk();
    logic [31:0] cur, ctl, sz, ba, w;
    int frame, b1, b2;
    bit first;
    logic [7:0] fb[$];
    cur = m_cur; frame = 0; first = 1'b1;
    forever begin
      ctl = mm[cur[12:2]];
      push_ev(EV_RD, cur, 0, 0, ctl[31] ? (first ? "R2" : "R9") : "R3");
      first = 1'b0;
      if (!ctl[31]) break;
      push_ev(EV_RD, cur + 4, 0, 0, "R4");
      sz = mm[(cur + 4) >> 2 & 32'h7ff];
      push_ev(EV_RD, cur + 8, 0, 0, "R4");
      ba = mm[(cur + 8) >> 2 & 32'h7ff];
      b1 = int'(sz[11:0]); b2 = int'(sz[27:16]);
      if (b1 > 2048 || b2 != 0) break;
      if (frame + b1 >= 8192) break;
      ba = ba & ~32'd3;
      for (int k = 0; k < (b1 + 3) / 4; k++) begin
        push_ev(EV_RD, ba + 32'(4 * k), 0, 0, "R6");
        w = mm[(ba + 32'(4 * k)) >> 2 & 32'h7ff];
        for (int j = 0; j < 4; j++) if (4 * k + j < b1) fb.push_back(w[8*j +: 8]);
      end
      frame += b1;
      if (ctl[29]) begin
        for (int i = 0; i < fb.size(); i++) push_ev(EV_BYTE, 0, {24'd0, fb[i]}, i == fb.size() - 1, "R7");
        push_ev(EV_DONE, 0, 0, 0, "R7");
        fb.delete(); frame = 0;
      end
      push_ev(EV_WR, cur, ctl & ~OWN, 0, "R8");
      mm[cur[12:2]] = ctl & ~OWN;
      cur = ctl[21] ? m_base : cur + 32;
    end
    m_cur = cur;
  endtask

  task automatic check_ev(input int kind, input logic [31:0] a, input logic [31:0] d,
                          input bit last, inout bit bad);
    ev_t e;
    if (expq.size() == 0) begin
      $display("FAIL unexpected event kind=%0d addr=%h data=%h (expected none)", kind, a, d);
      bad = 1'b1;
      return;
    end
    e = expq.pop_front();
    if (e.kind != kind || ((kind == EV_RD || kind == EV_WR) && e.a != a) ||
        ((kind == EV_WR || kind == EV_BYTE) && e.d != d) || (kind == EV_BYTE && e.last != last)) begin
      $display("FAIL %s: actual kind=%0d addr=%h data=%h last=%0d, expected kind=%0d addr=%h data=%h last=%0d",
               e.tag, kind, a, d, last, e.kind, e.a, e.d, e.last);
      bad = 1'b1;
    end
  endtask

  // Compare every clock against the model's event list.
  always @(negedge clk) begin
    if (rst_n && mon_en) begin
      bit bad;
      bad = 1'b0;
      if (mem_req)  check_ev(mem_we ? EV_WR : EV_RD, mem_addr, mem_we ? mem_wdata : 32'd0, 1'b0, bad);
      if (tx_valid) check_ev(EV_BYTE, 0, {24'd0, tx_data}, tx_last, bad);
      if (tx_done)  check_ev(EV_DONE, 0, 0, 1'b0, bad);
      vectors++;
      if (bad) errors++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic load_base(input logic [31:0] a);
    @(negedge clk); base_we = 1'b1; base_addr = a;
    @(negedge clk); base_we = 1'b0;
    m_base = a; m_cur = a;
  endtask

  task automatic pulse_poll();
    @(negedge clk); poll = 1'b1;
    @(negedge clk); poll = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    repeat (2) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    check(expq.size() == 0 && !busy, tag, expq.size(), 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2048; i++) set_w(32'(4 * i), 32'd0);
    for (int a = 32'h1000; a < 32'h2000; a += 4) set_w(32'(a), (32'(a) * 32'h9E37_79B1) ^ 32'h5A5A_0F0F);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !mem_req && !tx_valid && !tx_done, "R1", int'({busy, mem_req, tx_valid, tx_done}), 0);
    mon_en = 1'b1;

    // single-segment frame, partial last word
    load_base(32'h0000_0000);
    set_desc(32'h000, OWN | LST, 32'd10, 32'h1000);
    model_walk();
    pulse_poll();
    wait_idle("R2");

    // three segments, last carries ring end: wrap to base
    set_desc(32'h020, OWN, 32'd5, 32'h1100);
    set_desc(32'h040, OWN, 32'd7, 32'h1202);
    set_desc(32'h060, OWN | LST | RNG, 32'd4, 32'h1300);
    model_walk();
    pulse_poll();
    wait_idle("R9");

    // illegal buffer-1 length
    set_desc(32'h000, OWN | LST, 32'd2049, 32'h1000);
    model_walk();
    pulse_poll();
    wait_idle("R4");
    // nonzero buffer-2 length
    set_desc(32'h000, OWN | LST, 32'h0001_0008, 32'h1000);
    model_walk();
    pulse_poll();
    wait_idle("R4");
    // boundary length accepted
    set_desc(32'h000, OWN | LST, 32'd2048, 32'h1000);
    model_walk();
    pulse_poll();
    wait_idle("R4");

    // frame would reach capacity on the fourth segment
    for (int i = 1; i <= 4; i++) set_desc(32'(32 * i), OWN, 32'd2048, 32'h1000);
    model_walk();
    pulse_poll();
    wait_idle("R5");
    // fresh scan drops the earlier partial frame
    set_desc(32'h080, OWN | LST, 32'd3, 32'h1800);
    model_walk();
    pulse_poll();
    wait_idle("R10");

    // zero-length last segment
    set_desc(32'h0A0, OWN | LST, 32'd0, 32'h1000);
    model_walk();
    pulse_poll();
    wait_idle("R7");

    // poll lands in the stop cycle of an unowned descriptor
    model_walk();
    model_walk();
    @(negedge clk); poll = 1'b1;
    @(negedge clk); poll = 1'b0;
    check(mem_req && !mem_we && mem_addr == 32'h0C0, "R3", int'(mem_addr), 32'h0C0);
    @(posedge clk); #1 poll = 1'b1;
    @(posedge clk); #1 poll = 1'b0;
    wait_idle("R10");

    // several polls during play-out: one further scan
    set_desc(32'h0C0, OWN | LST, 32'd40, 32'h1400);
    model_walk();
    model_walk();
    pulse_poll();
    while (!tx_valid) @(negedge clk);
    repeat (3) begin
      poll = 1'b1; @(negedge clk);
      poll = 1'b0; @(negedge clk);
    end
    wait_idle("R10");

    mon_en = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule